// File: doc/BRIEF.md
# Processor Interrupt and Break Controller

This block decides, once per clock, whether a small pipelined processor leaves its normal flow to service an external interrupt, a maskable external break or a non-maskable break. When one of these events is accepted, it asks the pipeline to squash the instruction in decode and jump to a fixed vector. It also asks the register file to save the decode-stage program counter as the return address.

The block holds the machine status bits that govern these decisions: interrupt enable, break active, exception active, user mode and virtual mode, and saved copies of the two mode bits. Return-from-interrupt and return-from-break strobes from the execute stage re-arm the block. A whole-word status write port lets the processor load the status bits directly.

Vectors are a base address plus a fixed offset for each event kind. The return-address register index is also fixed for each event kind. All outputs are registered, so a decision made in one cycle shows on the outputs after the next rising edge.

Top module: `irq_brk_ctrl`

## Requirements
- R1: A synchronous reset clears every status bit and every strobe output. The status word reads 0 and no redirect or register write is issued in the cycle after reset is sampled.
- R2: An interrupt is accepted only when interrupt enable is 1 and break-active and exception-active are both 0. On acceptance, the next cycle shows a redirect to base + 0x10 and a register write of the decode PC to register index 14.
- R3: Accepting an interrupt clears interrupt enable, so a still-high interrupt line causes no second redirect. A return-from-interrupt strobe sets interrupt enable again.
- R4: An accepted break redirects to base + 0x18 and writes the decode PC to register index 16. It also sets break-active.
- R5: On break entry, user mode is copied into saved user mode and then cleared. Virtual mode is copied into saved virtual mode and then cleared.
- R6: A return-from-break strobe clears break-active. Both return strobes reload user mode and virtual mode from their saved copies.
- R7: The maskable break is not accepted while break-active is 1. The non-maskable break is accepted whether or not break-active is set, and back-to-back non-maskable pulses each produce a redirect.
- R8: When a break and an interrupt arrive in the same cycle, the break is taken. The interrupt is taken in a later cycle once it is no longer blocked.
- R9: Redirect and register write are single-cycle pulses that always occur together. A maskable break held high for several cycles produces exactly one redirect.
- R10: When no event is accepted and no return strobe is present, the status write port loads all seven bits. The status word layout is: bit0 interrupt enable, bit1 break-active, bit2 exception-active, bit3 user mode, bit4 saved user mode, bit5 virtual mode, bit6 saved virtual mode.
- R11: While exception-active is 1, the interrupt line is ignored. Once it is cleared, the interrupt is taken.
- R12: An accepted event takes precedence over a return strobe or a status write in the same cycle. The status write is then discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| irq_i | input | 1 | Level interrupt request |
| brk_i | input | 1 | Maskable break request, held until taken |
| nmbrk_i | input | 1 | Non-maskable break, one-cycle pulse |
| dec_pc_i | input | ADDR_W | PC of the instruction currently in decode |
| rti_i | input | 1 | Return-from-interrupt executed |
| rtb_i | input | 1 | Return-from-break executed |
| st_wr_i | input | 1 | Status word write enable |
| st_wdata_i | input | 7 | Status word write data |
| status_o | output | 7 | Current status word |
| redirect_o | output | 1 | Flush decode and jump to vec_addr_o |
| vec_addr_o | output | ADDR_W | Target vector address |
| rf_we_o | output | 1 | Return-address register write enable |
| rf_waddr_o | output | IDX_W | Return-address register index |
| rf_wdata_o | output | ADDR_W | Return address to write |

## Verification
The assertions assume the maskable break line drops before a return-from-break arrives. They also assume the non-maskable line is a pulse rather than a level, and that the two return strobes are never raised together. The stimulus holds the maskable break high only until its redirect appears and lowers it before any return-from-break. It drives the non-maskable line one cycle at a time and issues each return strobe alone. Same-cycle collisions are exercised only between the allowed pairs: break with interrupt, event with status write, and return-from-break with interrupt.

// File: rtl/ibc_pkg.sv
package ibc_pkg;

   // Status word; first field is the most significant bit, so ie lands on bit 0.
   typedef struct packed {
      logic vms;
      logic vm;
      logic ums;
      logic um;
      logic eip;
      logic bip;
      logic ie;
   } ibc_stat_t;

   localparam int STAT_W = $bits(ibc_stat_t);

   typedef enum logic [1:0] {
      EV_NONE = 2'd0,
      EV_INT  = 2'd1,
      EV_BRK  = 2'd2,
      EV_NMB  = 2'd3
   } ibc_ev_e;

   function automatic logic is_break(input ibc_ev_e ev);
      return (ev == EV_BRK) || (ev == EV_NMB);
   endfunction

endpackage

// File: rtl/ibc_arbiter.sv
module ibc_arbiter
   import ibc_pkg::*;
#(
   parameter bit NMB_OVER_BIP = 1'b1
) (
   input  logic      irq,
   input  logic      brk,
   input  logic      nmb,
   input  ibc_stat_t st,
   output ibc_ev_e   ev
);

   logic nmb_ok;
   logic brk_ok;
   logic irq_ok;

   generate
      if (NMB_OVER_BIP) begin : g_nmb_free
         assign nmb_ok = nmb;
      end else begin : g_nmb_gated
         assign nmb_ok = nmb & ~st.bip;
      end
   endgenerate

   assign brk_ok = brk & ~st.bip;
   assign irq_ok = irq & st.ie & ~st.bip & ~st.eip;

   always_comb begin
      if (nmb_ok) begin
         ev = EV_NMB;
      end else if (brk_ok) begin
         ev = EV_BRK;
      end else if (irq_ok) begin
         ev = EV_INT;
      end else begin
         ev = EV_NONE;
      end
   end

endmodule

// File: rtl/ibc_status.sv
module ibc_status
   import ibc_pkg::*;
(
   input  logic      clk,
   input  logic      rst,
   input  ibc_ev_e   ev,
   input  logic      rti,
   input  logic      rtb,
   input  logic      wr,
   input  ibc_stat_t wdata,
   output ibc_stat_t st
);

   ibc_stat_t st_q;
   ibc_stat_t st_d;

   always_comb begin
      st_d = st_q;
      if (is_break(ev)) begin
         st_d.bip = 1'b1;
         st_d.ums = st_q.um;
         st_d.um  = 1'b0;
         st_d.vms = st_q.vm;
         st_d.vm  = 1'b0;
      end else if (ev == EV_INT) begin
         st_d.ie = 1'b0;
      end else if (rtb) begin
         st_d.bip = 1'b0;
         st_d.um  = st_q.ums;
         st_d.vm  = st_q.vms;
      end else if (rti) begin
         st_d.ie  = 1'b1;
         st_d.um  = st_q.ums;
         st_d.vm  = st_q.vms;
      end else if (wr) begin
         st_d = wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q <= '0;
      end else begin
         st_q <= st_d;
      end
   end

   assign st = st_q;

   // R5
   brk_mode_save_chk: assert property (@(posedge clk) disable iff (rst)
      is_break(ev) |=> (st_q.ums == $past(st_q.um)) && (st_q.vms == $past(st_q.vm))
                       && !st_q.um && !st_q.vm);

   // R6
   rtb_restore_chk: assert property (@(posedge clk) disable iff (rst)
      (rtb && ev == EV_NONE) |=> !st_q.bip && (st_q.um == $past(st_q.ums))
                                 && (st_q.vm == $past(st_q.vms)));

   // R3
   rti_rearm_chk: assert property (@(posedge clk) disable iff (rst)
      (rti && !rtb && ev == EV_NONE) |=> st_q.ie);

endmodule

// File: rtl/ibc_redirect.sv
module ibc_redirect
   import ibc_pkg::*;
#(
   parameter int              ADDR_W    = 32,
   parameter int              IDX_W     = 5,
   parameter logic [ADDR_W-1:0] INT_VEC = '0,
   parameter logic [ADDR_W-1:0] BRK_VEC = '0,
   parameter int              INT_IDX   = 14,
   parameter int              BRK_IDX   = 16,
   parameter bit              ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  ibc_ev_e           ev,
   input  logic [ADDR_W-1:0] pc,
   output logic              redirect,
   output logic [ADDR_W-1:0] vec,
   output logic              we,
   output logic [IDX_W-1:0]  waddr,
   output logic [ADDR_W-1:0] wdata
);

   localparam logic [IDX_W-1:0] INT_IDX_L = IDX_W'(INT_IDX);
   localparam logic [IDX_W-1:0] BRK_IDX_L = IDX_W'(BRK_IDX);

   logic              take;
   logic [ADDR_W-1:0] vec_sel;
   logic [IDX_W-1:0]  idx_sel;

   assign take    = (ev != EV_NONE);
   assign vec_sel = is_break(ev) ? BRK_VEC : INT_VEC;
   assign idx_sel = is_break(ev) ? BRK_IDX_L : INT_IDX_L;

   always_ff @(posedge clk) begin
      if (rst) begin
         redirect <= 1'b0;
         we       <= 1'b0;
      end else begin
         redirect <= take;
         we       <= take;
      end
   end

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         always_ff @(posedge clk) begin
            if (rst || !take) begin
               vec   <= '0;
               waddr <= '0;
               wdata <= '0;
            end else begin
               vec   <= vec_sel;
               waddr <= idx_sel;
               wdata <= pc;
            end
         end
      end else begin : g_hold_last
         always_ff @(posedge clk) begin
            if (rst) begin
               vec   <= '0;
               waddr <= '0;
               wdata <= '0;
            end else if (take) begin
               vec   <= vec_sel;
               waddr <= idx_sel;
               wdata <= pc;
            end
         end
      end
   endgenerate

   // R2
   ret_pc_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> redirect && we && (wdata == $past(pc)));

endmodule

// File: rtl/irq_brk_ctrl.sv
module irq_brk_ctrl
   import ibc_pkg::*;
#(
   parameter int              ADDR_W       = 32,
   parameter int              IDX_W        = 5,
   parameter logic [ADDR_W-1:0] BASE_VEC   = 32'h0000_4000,
   parameter int              INT_OFS      = 'h10,
   parameter int              BRK_OFS      = 'h18,
   parameter int              INT_IDX      = 14,
   parameter int              BRK_IDX      = 16,
   parameter bit              NMB_OVER_BIP = 1'b1,
   parameter bit              ZERO_IDLE    = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              irq_i,
   input  logic              brk_i,
   input  logic              nmbrk_i,
   input  logic [ADDR_W-1:0] dec_pc_i,
   input  logic              rti_i,
   input  logic              rtb_i,
   input  logic              st_wr_i,
   input  logic [6:0]        st_wdata_i,
   output logic [6:0]        status_o,
   output logic              redirect_o,
   output logic [ADDR_W-1:0] vec_addr_o,
   output logic              rf_we_o,
   output logic [IDX_W-1:0]  rf_waddr_o,
   output logic [ADDR_W-1:0] rf_wdata_o
);

   localparam logic [ADDR_W-1:0] INT_VEC   = BASE_VEC + ADDR_W'(INT_OFS);
   localparam logic [ADDR_W-1:0] BRK_VEC   = BASE_VEC + ADDR_W'(BRK_OFS);
   localparam logic [IDX_W-1:0]  INT_IDX_L = IDX_W'(INT_IDX);
   localparam logic [IDX_W-1:0]  BRK_IDX_L = IDX_W'(BRK_IDX);

   generate
      if (ADDR_W < 8) begin : g_bad_addr
         $error("ADDR_W too small");
      end
      if (INT_OFS == BRK_OFS) begin : g_bad_ofs
         $error("interrupt and break offsets must differ");
      end
      if (INT_IDX == BRK_IDX) begin : g_bad_idx
         $error("return register indices must differ");
      end
      if (INT_IDX >= (1 << IDX_W) || BRK_IDX >= (1 << IDX_W)) begin : g_bad_w
         $error("register index does not fit IDX_W");
      end
      if (STAT_W != 7) begin : g_bad_stat
         $error("status word must be 7 bits");
      end
   endgenerate

   ibc_stat_t st;
   ibc_ev_e   ev;

   ibc_arbiter #(
      .NMB_OVER_BIP(NMB_OVER_BIP)
   ) u_arb (
      .irq(irq_i),
      .brk(brk_i),
      .nmb(nmbrk_i),
      .st (st),
      .ev (ev)
   );

   ibc_status u_stat (
      .clk  (clk),
      .rst  (rst),
      .ev   (ev),
      .rti  (rti_i),
      .rtb  (rtb_i),
      .wr   (st_wr_i),
      .wdata(ibc_stat_t'(st_wdata_i)),
      .st   (st)
   );

   ibc_redirect #(
      .ADDR_W   (ADDR_W),
      .IDX_W    (IDX_W),
      .INT_VEC  (INT_VEC),
      .BRK_VEC  (BRK_VEC),
      .INT_IDX  (INT_IDX),
      .BRK_IDX  (BRK_IDX),
      .ZERO_IDLE(ZERO_IDLE)
   ) u_redir (
      .clk     (clk),
      .rst     (rst),
      .ev      (ev),
      .pc      (dec_pc_i),
      .redirect(redirect_o),
      .vec     (vec_addr_o),
      .we      (rf_we_o),
      .waddr   (rf_waddr_o),
      .wdata   (rf_wdata_o)
   );

   assign status_o = st;

   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (status_o == '0) && !redirect_o && !rf_we_o);

   // R2
   int_gate_chk: assert property (@(posedge clk) disable iff (rst)
      (redirect_o && rf_waddr_o == INT_IDX_L) |->
         $past(st.ie) && !$past(st.bip) && !$past(st.eip) && (vec_addr_o == INT_VEC));

   // R3
   int_once_chk: assert property (@(posedge clk) disable iff (rst)
      (redirect_o && rf_waddr_o == INT_IDX_L) |-> !st.ie);

   // R4
   brk_entry_chk: assert property (@(posedge clk) disable iff (rst)
      (redirect_o && rf_waddr_o == BRK_IDX_L) |-> st.bip && (vec_addr_o == BRK_VEC));

   // R7
   bip_block_chk: assert property (@(posedge clk) disable iff (rst)
      (st.bip && !nmbrk_i) |=> !redirect_o);

   // R8
   brk_first_chk: assert property (@(posedge clk) disable iff (rst)
      (brk_i && irq_i && !st.bip) |=> redirect_o && (rf_waddr_o == BRK_IDX_L));

   // R9
   strobe_pair_chk: assert property (@(posedge clk) disable iff (rst)
      redirect_o == rf_we_o);

endmodule

// File: tb/irq_brk_ctrl_tb.sv
module irq_brk_ctrl_tb;

   localparam logic [31:0] BASE = 32'h0000_4000;
   localparam logic [31:0] VINT = BASE + 32'h10;
   localparam logic [31:0] VBRK = BASE + 32'h18;

   typedef struct {
      logic [4:0]  idx;
      logic [31:0] pc;
      logic [31:0] vec;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        irq_i = 1'b0, brk_i = 1'b0, nmbrk_i = 1'b0;
   logic [31:0] dec_pc_i = '0;
   logic        rti_i = 1'b0, rtb_i = 1'b0, st_wr_i = 1'b0;
   logic [6:0]  st_wdata_i = '0;
   logic [6:0]  status_o;
   logic        redirect_o, rf_we_o;
   logic [31:0] vec_addr_o, rf_wdata_o;
   logic [4:0]  rf_waddr_o;

   int   n_chk = 0;
   int   n_err = 0;
   bit   done = 1'b0;
   exp_t sb[$];

   always #5 clk = ~clk;

   irq_brk_ctrl u_dut (
      .clk(clk), .rst(rst), .irq_i(irq_i), .brk_i(brk_i), .nmbrk_i(nmbrk_i),
      .dec_pc_i(dec_pc_i), .rti_i(rti_i), .rtb_i(rtb_i), .st_wr_i(st_wr_i),
      .st_wdata_i(st_wdata_i), .status_o(status_o), .redirect_o(redirect_o),
      .vec_addr_o(vec_addr_o), .rf_we_o(rf_we_o), .rf_waddr_o(rf_waddr_o),
      .rf_wdata_o(rf_wdata_o)
   );

   task automatic push(input logic [4:0] idx, input logic [31:0] pc,
                       input logic [31:0] vec, input string tag);
      exp_t e;
      e.idx = idx; e.pc = pc; e.vec = vec; e.tag = tag;
      sb.push_back(e);
   endtask

   // Apply one cycle of stimulus at a falling edge; return at the next falling edge.
   task automatic drive(input logic irq, input logic brk, input logic nm,
                        input logic rti, input logic rtb, input logic wr,
                        input logic [6:0] wd, input logic [31:0] pc);
      irq_i = irq; brk_i = brk; nmbrk_i = nm; rti_i = rti; rtb_i = rtb;
      st_wr_i = wr; st_wdata_i = wd; dec_pc_i = pc;
      @(negedge clk);
   endtask

   task automatic idle();
      drive(0, 0, 0, 0, 0, 0, 7'h0, 32'h0);
   endtask

   task automatic chk_st(input logic [6:0] exp, input string tag);
      n_chk++;
      if (status_o !== exp) begin
         n_err++;
         $display("FAIL %s status actual=%b expected=%b", tag, status_o, exp);
      end
   endtask

   task automatic chk_quiet(input string tag);
      n_chk++;
      if (redirect_o !== 1'b0) begin
         n_err++;
         $display("FAIL %s redirect actual=%b expected=0", tag, redirect_o);
      end
   endtask

   // Monitor: pops one expected item per observed redirect.
   always @(negedge clk) begin
      if (!rst && (redirect_o === 1'b1 || rf_we_o === 1'b1)) begin
         n_chk++;
         if (redirect_o !== rf_we_o) begin
            n_err++;
            $display("FAIL R9 strobes actual=%b/%b expected equal", redirect_o, rf_we_o);
         end else if (sb.size() == 0) begin
            n_err++;
            $display("FAIL R9 unexpected redirect actual=1 expected=0 pc=%h", rf_wdata_o);
         end else begin
            exp_t e;
            e = sb.pop_front();
            if (rf_waddr_o !== e.idx || rf_wdata_o !== e.pc || vec_addr_o !== e.vec) begin
               n_err++;
               $display("FAIL %s actual idx=%0d pc=%h vec=%h expected idx=%0d pc=%h vec=%h",
                        e.tag, rf_waddr_o, rf_wdata_o, vec_addr_o, e.idx, e.pc, e.vec);
            end
         end
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk_st(7'b0000000, "R1");
      chk_quiet("R1");

      // R2: interrupt enable is 0 after reset, so the line is ignored
      drive(1, 0, 0, 0, 0, 0, 7'h0, 32'h0000_0080);
      chk_quiet("R2");

      // R10: load ie, um, vm (bits 0, 3, 5)
      drive(0, 0, 0, 0, 0, 1, 7'b0101001, 32'h0);
      chk_st(7'b0101001, "R10");

      // R2 / R3: interrupt taken, ie cleared
      push(5'd14, 32'h0000_0100, VINT, "R2");
      drive(1, 0, 0, 0, 0, 0, 7'h0, 32'h0000_0100);
      chk_st(7'b0101000, "R3");
      drive(1, 0, 0, 0, 0, 0, 7'h0, 32'h0000_0104);
      chk_quiet("R3");

      // R3 / R6: return-from-interrupt sets ie and reloads modes from saved (0)
      drive(0, 0, 0, 1, 0, 0, 7'h0, 32'h0);
      chk_st(7'b0000001, "R3");
      drive(0, 0, 0, 0, 0, 1, 7'b0101001, 32'h0);

      // R8 / R4 / R5: break and interrupt together; break wins
      push(5'd16, 32'h0000_0200, VBRK, "R8");
      drive(1, 1, 0, 0, 0, 0, 7'h0, 32'h0000_0200);
      chk_st(7'b1010011, "R5");

      // R7 / R9: held break and interrupt blocked while break active
      drive(1, 1, 0, 0, 0, 0, 7'h0, 32'h0000_0204);
      chk_quiet("R7");
      drive(1, 1, 0, 0, 0, 0, 7'h0, 32'h0000_0208);
      chk_quiet("R9");

      // R6: return-from-break clears bip and restores modes
      drive(0, 0, 0, 0, 1, 0, 7'h0, 32'h0);
      chk_st(7'b1111001, "R6");

      // R7: non-maskable break taken while break active
      drive(0, 0, 0, 0, 0, 1, 7'b0000010, 32'h0);
      push(5'd16, 32'h0000_0300, VBRK, "R7");
      drive(0, 0, 1, 0, 0, 0, 7'h0, 32'h0000_0300);
      chk_st(7'b0000010, "R7");

      // R8: interrupt pending during return-from-break, taken the next cycle
      drive(0, 0, 0, 0, 0, 1, 7'b0000011, 32'h0);
      drive(1, 0, 0, 0, 1, 0, 7'h0, 32'h0000_03F0);
      chk_quiet("R8");
      chk_st(7'b0000001, "R8");
      push(5'd14, 32'h0000_0400, VINT, "R8");
      drive(1, 0, 0, 0, 0, 0, 7'h0, 32'h0000_0400);
      chk_st(7'b0000000, "R8");

      // R11: exception active blocks interrupts
      drive(0, 0, 0, 0, 0, 1, 7'b0000101, 32'h0);
      drive(1, 0, 0, 0, 0, 0, 7'h0, 32'h0000_0480);
      chk_quiet("R11");
      chk_st(7'b0000101, "R11");
      drive(0, 0, 0, 0, 0, 1, 7'b0000001, 32'h0);
      push(5'd14, 32'h0000_0500, VINT, "R11");
      drive(1, 0, 0, 0, 0, 0, 7'h0, 32'h0000_0500);

      // R12: break entry wins over a status write in the same cycle
      push(5'd16, 32'h0000_0600, VBRK, "R12");
      drive(0, 1, 0, 0, 0, 1, 7'b1111111, 32'h0000_0600);
      chk_st(7'b0000010, "R12");

      // R7: back-to-back non-maskable pulses
      push(5'd16, 32'h0000_0700, VBRK, "R7");
      drive(0, 0, 1, 0, 0, 0, 7'h0, 32'h0000_0700);
      push(5'd16, 32'h0000_0704, VBRK, "R7");
      drive(0, 0, 1, 0, 0, 0, 7'h0, 32'h0000_0704);
      idle();
      chk_quiet("R9");
      n_chk++;
      if (sb.size() != 0) begin
         n_err++;
         $display("FAIL R9 missing redirects actual=%0d expected=0", sb.size());
      end

      // R1: reset mid-run clears the status word
      rst = 1'b1;
      @(negedge clk);
      chk_st(7'b0000000, "R1");
      rst = 1'b0;
      idle();
      finish_run();
   end

endmodule